// File: doc/BRIEF.md
# Region write-protected RAM

A single-port synchronous byte-wide RAM whose writes are filtered by a region mask. The array is divided into equal, fixed-size regions, and each region has its own enable bit in a mask register. A write aimed at a region whose enable bit is clear is dropped without any indication. A write to an enabled region updates memory as normal. Reads of the array are never filtered. Read data comes from a register and appears one cycle after the read request.

The mask register shares the bus with the array and has one decoded address just above it. It can always be read. It accepts a new value only while an external privilege input is high. That input is meant to carry the processor's interrupt-state flag. Initialization code runs with the flag high, so it can set up the mask before the flag drops and the protection applies. With a suitable mask, software can make parts of memory read-only, for example to keep tasks from overwriting each other.

With default parameters the array is 4096 bytes in 8 regions of 512 bytes each. The bus address is 13 bits wide: 0x0000–0x0FFF select the array, 0x1000 selects the mask register, and 0x1001–0x1FFF select nothing.

Top module: `region_guard_ram`

## Requirements
- R1: After a synchronous reset, the mask register reads back 0xFF, so every region is writable. rd_data is 0x00 until the first read completes.
- R2: A read request (rd_en high at a rising edge) places the addressed byte on rd_data after that edge. rd_data keeps its value while rd_en is low.
- R3: A write (wr_en high) to an array address whose region bit is 1 stores wr_data at that address.
- R4: A write to an array address whose region bit is 0 leaves the memory contents unchanged. The region number is addr[11:9].
- R5: A write to address 0x1000 while priv is high loads wr_data into the mask. Bit n enables region n, which covers addresses n*512 to n*512+511.
- R6: A write to address 0x1000 while priv is low leaves the mask unchanged.
- R7: A read of address 0x1000 returns the current mask, whatever the level of priv.
- R8: Reads of the array return the stored data whatever the mask holds, including reads of locked regions.
- R9: When a read and a write hit the same array address in one cycle, rd_data returns the byte held before the write. The new byte is visible to later reads.
- R10: Addresses 0x1001 to 0x1FFF decode to nothing: a read returns 0x00, and a write changes neither the mask nor the array.
- R11: Region edges are exact. With only bit 0 of the mask cleared, a write to 0x01FF is dropped and a write to 0x0200 is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Bus address: array, mask register or unused |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| priv | input | 1 | Privilege flag; enables mask register updates |
| rd_data | output | 8 | Registered read data |

## Verification
Writes are made to every region, with byte values that differ per region and with the extremes 0x00 and 0xFF, so that a wrong region or address mapping shows as a wrong byte. The mask is then narrowed two ways. In the first, the upper half is locked, which separates gated writes from ungated ones and shows that reads ignore the mask. In the second, only region 0 is locked, and writes on both sides of the 0x01FF/0x0200 edge expose an off-by-one in the region decode. Mask writes are tried with priv both low and high, a same-cycle read and write of one address shows whether the read returns the byte before or after the write, and accesses to the unused addresses confirm that they reach neither the mask nor an aliased array byte.

// File: rtl/rgr_pkg.sv
package rgr_pkg;

    // Default geometry: 4 KiB array, 8 regions, byte data
    localparam int RGR_ADDR_W      = 12;
    localparam int RGR_DATA_W      = 8;
    localparam int RGR_REGION_BITS = 3;

    // Source selected for the registered read path
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARRAY = 2'd1,
        SRC_MASK  = 2'd2
    } rgr_src_t;

    // Decoded view of one bus access
    typedef struct packed {
        rgr_src_t src;
        logic     wr;
        logic     rd;
    } rgr_access_t;

    // Number of regions for a given region-index width
    function automatic int region_count(input int region_bits);
        return 1 << region_bits;
    endfunction

endpackage

// File: rtl/rgr_decode.sv
module rgr_decode
    import rgr_pkg::*;
#(
    parameter int ADDR_W = RGR_ADDR_W,
    localparam int BUS_AW = ADDR_W + 1
) (
    input  logic [BUS_AW-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output rgr_access_t       acc,
    output logic [ADDR_W-1:0] offset
);

    // The mask register sits at the first address past the array
    localparam logic [BUS_AW-1:0] MASK_ADDR = {1'b1, {ADDR_W{1'b0}}};

    always_comb begin
        offset = addr[ADDR_W-1:0];
        acc.wr = wr_en;
        acc.rd = rd_en;
        if (!addr[BUS_AW-1])
            acc.src = SRC_ARRAY;
        else if (addr == MASK_ADDR)
            acc.src = SRC_MASK;
        else
            acc.src = SRC_NONE;
    end

endmodule

// File: rtl/rgr_mask_reg.sv
module rgr_mask_reg
    import rgr_pkg::*;
#(
    parameter int DATA_W      = RGR_DATA_W,
    parameter int REGION_BITS = RGR_REGION_BITS,
    localparam int NREG       = 1 << REGION_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv,
    input  logic              load,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NREG-1:0]   mask_q
);

    // One enable flop per region; the update needs both a load and privilege
    for (genvar n = 0; n < NREG; n++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[n] <= 1'b1;
            else if (load && priv)
                mask_q[n] <= wr_data[n];
        end
    end

endmodule

// File: rtl/rgr_array.sv
module rgr_array
    import rgr_pkg::*;
#(
    parameter int ADDR_W = RGR_ADDR_W,
    parameter int DATA_W = RGR_DATA_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Read-first single port: q captures the byte present before this edge's write
    always_ff @(posedge clk) begin
        if (re)
            q <= mem[addr];
        if (we)
            mem[addr] <= wd;
    end

endmodule

// File: rtl/region_guard_ram.sv
module region_guard_ram
    import rgr_pkg::*;
#(
    parameter int ADDR_W      = RGR_ADDR_W,
    parameter int DATA_W      = RGR_DATA_W,
    parameter int REGION_BITS = RGR_REGION_BITS,
    localparam int BUS_AW     = ADDR_W + 1,
    localparam int NREG       = region_count(REGION_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              priv,
    output logic [DATA_W-1:0] rd_data
);

    rgr_access_t       acc;
    logic [ADDR_W-1:0] offset;
    logic [NREG-1:0]   mask_q;
    logic              mask_load;
    logic              region_open;
    logic              arr_we;
    logic              arr_re;
    logic [DATA_W-1:0] arr_q;
    rgr_src_t          src_q;
    logic [DATA_W-1:0] mask_rd_q;

    rgr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .acc    (acc),
        .offset (offset)
    );

    assign mask_load = acc.wr && (acc.src == SRC_MASK);

    rgr_mask_reg #(.DATA_W(DATA_W), .REGION_BITS(REGION_BITS)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .priv    (priv),
        .load    (mask_load),
        .wr_data (wr_data),
        .mask_q  (mask_q)
    );

    // Region index is the top REGION_BITS of the array offset
    assign region_open = mask_q[offset[ADDR_W-1 -: REGION_BITS]];
    assign arr_we      = acc.wr && (acc.src == SRC_ARRAY) && region_open;
    assign arr_re      = acc.rd && (acc.src == SRC_ARRAY);

    rgr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk  (clk),
        .we   (arr_we),
        .re   (arr_re),
        .addr (offset),
        .wd   (wr_data),
        .q    (arr_q)
    );

    // Read source and mask snapshot are captured alongside the array read
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= SRC_NONE;
            mask_rd_q <= '0;
        end else if (acc.rd) begin
            src_q     <= acc.src;
            mask_rd_q <= DATA_W'(mask_q);
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_ARRAY: rd_data = arr_q;
            SRC_MASK:  rd_data = mask_rd_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rgr_checker.sv
module rgr_checker #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int REGION_BITS = 3,
    localparam int BUS_AW     = ADDR_W + 1,
    localparam int NREG       = 1 << REGION_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic              priv,
    input logic [DATA_W-1:0] rd_data,
    input logic [NREG-1:0]   mask_q,
    input logic              arr_we
);

    localparam logic [BUS_AW-1:0] MASK_ADDR = {1'b1, {ADDR_W{1'b0}}};

    logic in_array;
    logic at_mask;
    logic bit_set;
    assign in_array = (addr < MASK_ADDR);
    assign at_mask  = (addr == MASK_ADDR);
    assign bit_set  = mask_q[addr[ADDR_W-1 -: REGION_BITS]];

    // R1
    mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == {NREG{1'b1}}));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R3
    open_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_array && bit_set) |-> arr_we);

    // R4
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_array && !bit_set) |-> !arr_we);

    // R5
    mask_update_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && at_mask && priv) |=> (mask_q == $past(wr_data[NREG-1:0])));

    // R6
    mask_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && at_mask && priv) |=> $stable(mask_q));

    // R10
    hole_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_array && !at_mask) |=> (rd_data == '0));

endmodule

bind region_guard_ram rgr_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REGION_BITS (REGION_BITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .priv    (priv),
    .rd_data (rd_data),
    .mask_q  (mask_q),
    .arr_we  (arr_we)
);

// File: tb/tb_region_guard_ram.sv
module tb_region_guard_ram;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] addr;
    logic [7:0]  wr_data;
    logic        wr_en;
    logic        rd_en;
    logic        priv;
    logic [7:0]  rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam logic [12:0] MASK_ADDR = 13'h1000;

    always #4 clk = ~clk;

    region_guard_ram dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .priv(priv), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One bus cycle: drive after a falling edge, release after the rising edge
    task automatic bus(input logic [12:0] a, input logic [7:0] d,
                       input logic we, input logic re, input logic p);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = we; rd_en = re; priv = p;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic p);
        bus(a, d, 1'b1, 1'b0, p);
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] v);
        bus(a, 8'h00, 1'b0, 1'b1, 1'b0);
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rd_data after reset", rd_data, 8'h00);
        rd(MASK_ADDR, v);
        check("R1 mask after reset", v, 8'hFF);
    endtask

    task automatic t_all_regions();
        logic [7:0] v;
        for (int n = 0; n < 8; n++)
            wr(13'(n * 512 + n * 37), 8'(8'hA5 ^ (n * 8'h13)), 1'b0);
        for (int n = 0; n < 8; n++) begin
            rd(13'(n * 512 + n * 37), v);
            check("R3 region pattern", v, 8'(8'hA5 ^ (n * 8'h13)));
        end
        wr(13'h0000, 8'h00, 1'b0);
        wr(13'h0FFF, 8'hFF, 1'b0);
        rd(13'h0FFF, v); check("R3 top byte", v, 8'hFF);
        rd(13'h0000, v); check("R3 bottom byte", v, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        rd(13'h0FFF, v);
        @(negedge clk); addr = 13'h0000;
        repeat (3) @(negedge clk);
        check("R2 hold with rd_en low", rd_data, 8'hFF);
    endtask

    task automatic t_priv();
        logic [7:0] v;
        wr(MASK_ADDR, 8'h0F, 1'b0);
        rd(MASK_ADDR, v); check("R6 unprivileged mask write", v, 8'hFF);
        wr(MASK_ADDR, 8'h0F, 1'b1);
        @(negedge clk); priv = 1'b1; addr = MASK_ADDR; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; priv = 1'b0;
        check("R7 mask read with priv high", rd_data, 8'h0F);
        rd(MASK_ADDR, v); check("R5 privileged mask write", v, 8'h0F);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        // mask 0x0F: regions 4..7 locked; 0x0800+4*37 was written earlier
        wr(13'h0800 + 13'd148, 8'h3C, 1'b0);
        rd(13'h0800 + 13'd148, v);
        check("R4 locked region write dropped", v, 8'(8'hA5 ^ (4 * 8'h13)));
        check("R8 locked region readable", v, 8'(8'hA5 ^ (4 * 8'h13)));
        rd(13'h0FFF, v); check("R8 top region readable", v, 8'hFF);
        wr(13'h0600, 8'h6E, 1'b0);
        rd(13'h0600, v); check("R3 open region under mask", v, 8'h6E);
    endtask

    task automatic t_boundary();
        logic [7:0] v;
        wr(MASK_ADDR, 8'hFF, 1'b1);
        wr(13'h01FF, 8'h11, 1'b0);
        wr(13'h0200, 8'h22, 1'b0);
        wr(MASK_ADDR, 8'hFE, 1'b1);
        wr(13'h01FF, 8'h99, 1'b0);
        wr(13'h0200, 8'h77, 1'b0);
        rd(13'h01FF, v); check("R11 last byte of region 0", v, 8'h11);
        rd(13'h0200, v); check("R11 first byte of region 1", v, 8'h77);
    endtask

    task automatic t_rdw();
        logic [7:0] v;
        wr(MASK_ADDR, 8'hFF, 1'b1);
        wr(13'h0123, 8'h5A, 1'b0);
        bus(13'h0123, 8'hC3, 1'b1, 1'b1, 1'b0);
        check("R9 read during write returns old", rd_data, 8'h5A);
        rd(13'h0123, v); check("R9 new byte visible later", v, 8'hC3);
    endtask

    task automatic t_hole();
        logic [7:0] v;
        wr(13'h0001, 8'h4B, 1'b0);
        wr(13'h1001, 8'h00, 1'b1);
        wr(13'h1FFF, 8'h00, 1'b1);
        rd(MASK_ADDR, v); check("R10 hole write leaves mask", v, 8'hFF);
        rd(13'h0001, v); check("R10 hole write leaves array", v, 8'h4B);
        rd(13'h1001, v); check("R10 hole read is zero", v, 8'h00);
        rd(13'h1FFF, v); check("R10 top hole read is zero", v, 8'h00);
    endtask

    initial begin
        addr = '0; wr_data = '0; wr_en = 1'b0; rd_en = 1'b0; priv = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_all_regions();
        t_hold();
        t_priv();
        t_lock();
        t_boundary();
        t_rdw();
        t_hole();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule